// File: doc/BRIEF.md
# Reference Clock Inactivity Monitor

The block decides, on a slow time base, whether one reference clock input is alive. The system clock domain divides time into sampling intervals, each closed by a one-cycle tick strobe (nominally every 1/8 s). An interval in which no rising edge of the reference was seen is inactive. Each inactive interval adds one count to a saturating bucket. Active intervals drain the bucket at a rate of one count per 2^decay active intervals.

An alarm output is raised when the bucket count reaches an upper threshold. It is cleared only when the count has drained to a lower threshold or below. The rise time and the clear time are therefore tuned independently. Several configuration sets (upper threshold, lower threshold, bucket size, decay exponent) sit side by side on the ports, and a select input picks the set that is applied. With upper threshold 6 the alarm rises after 6 empty intervals (0.75 s). With decay exponent 1, bucket size 8 and lower threshold 4, a full bucket clears after 8 active intervals (1.0 s).

Top module: `amon_leaky_bucket`

## Requirements
- R1: After reset the alarm output is 0 and the bucket is empty.
- R2: An interval ending with a tick and containing no rising reference edge adds exactly one count. Starting from an empty bucket, the alarm goes to 1 on the tick that closes the upper-threshold-th consecutive inactive interval.
- R3: The count saturates at the selected bucket size. After any number of inactive intervals beyond the bucket size, a full bucket clears in exactly 2^decay × (size − lower) active intervals.
- R4: Active intervals remove one count per 2^decay of them. Decay 0 removes one count on every active interval.
- R5: Hysteresis: once set, the alarm stays at 1 while the count is above the lower threshold, even when the count is below the upper threshold. It goes to 0 on the tick where the count becomes less than or equal to the lower threshold.
- R6: The count never goes below zero. After any run of active intervals, the upper-threshold number of inactive intervals is again needed to raise the alarm.
- R7: An interval with at least one rising edge of the reference clock, as seen through a two-flop synchronizer into the system clock, counts as active.
- R8: An inactive interval restarts the decay progress. With intermittent inactivity the alarm can rise even though inactive intervals are not consecutive. For example, alternating inactive and active intervals with decay 1 raise it after upper-threshold inactive ones. With decay 0 the same pattern never raises it.
- R9: cfg_sel selects configuration set k, taken from bits [k*W +: W] of each configuration bus. Values in non-selected sets have no effect on the alarm.
- R10: The alarm output changes only on the clock edge at which the tick strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Monitored reference clock (asynchronous) |
| tick_i | input | 1 | One-cycle strobe closing each sampling interval |
| cfg_sel | input | SW | Index of the configuration set in use |
| upper_thr | input | NCFG*CW | Upper thresholds, set k in [k*CW +: CW] |
| lower_thr | input | NCFG*CW | Lower thresholds, set k in [k*CW +: CW] |
| bucket_sz | input | NCFG*CW | Bucket sizes, set k in [k*CW +: CW] |
| decay_exp | input | NCFG*DW | Decay exponents, set k in [k*DW +: DW] |
| alarm_o | output | 1 | Registered inactivity alarm |

## Verification
Reference edges cross three system-clock flops before they can mark the interval. The bench therefore places its reference pulse early in each 16-cycle interval, well ahead of the tick. The only result, the alarm, is updated on the clock edge that samples tick_i high. It is due at the falling edge that follows that edge. The driver pushes the expected alarm for every interval at exactly that falling edge. The monitor pops and compares at falling edges only. The alarm cannot move between ticks, so a comparison made one falling edge later still sees the same value.

// File: rtl/amon_pkg.sv
package amon_pkg;
  localparam int unsigned AMON_NCFG = 4;
  localparam int unsigned AMON_CW   = 8;
  localparam int unsigned AMON_DW   = 3;
endpackage

// File: rtl/amon_edge_sync.sv
module amon_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk,
  input  logic tick,
  output logic act
);
  logic [2:0] sync_q;
  logic       seen_q, seen_d, rise;

  assign rise   = sync_q[1] & ~sync_q[2];
  assign act    = seen_q | rise;
  assign seen_d = tick ? 1'b0 : (seen_q | rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      seen_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], ref_clk};
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/amon_bucket.sv
module amon_bucket #(
  parameter int unsigned CW = 8,
  parameter int unsigned DW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          act,
  input  logic [CW-1:0] size,
  input  logic [DW-1:0] decay,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d
);
  localparam int unsigned DCW = (1 << DW) - 1;

  logic [DCW-1:0] dcnt_q, dcnt_d, mask;

  assign mask = ~({DCW{1'b1}} << decay);

  always_comb begin
    cnt_d  = cnt_q;
    dcnt_d = dcnt_q;
    if (tick) begin
      if (!act) begin
        dcnt_d = '0;
        cnt_d  = (cnt_q >= size) ? size : cnt_q + 1'b1;
      end else if (dcnt_q == mask) begin
        dcnt_d = '0;
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      end else begin
        dcnt_d = dcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dcnt_q <= '0;
    end else if (tick) begin
      cnt_q  <= cnt_d;
      dcnt_q <= dcnt_d;
    end
  end
endmodule

// File: rtl/amon_alarm.sv
module amon_alarm #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] cnt_d,
  input  logic [CW-1:0] upper,
  input  logic [CW-1:0] lower,
  output logic          alarm_q
);
  logic alarm_d;

  always_comb begin
    if (alarm_q) alarm_d = (cnt_d > lower);
    else         alarm_d = (cnt_d >= upper);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    alarm_q <= 1'b0;
    else if (tick) alarm_q <= alarm_d;
  end
endmodule

// File: rtl/amon_leaky_bucket.sv
module amon_leaky_bucket #(
  parameter int unsigned NCFG = amon_pkg::AMON_NCFG,
  parameter int unsigned CW   = amon_pkg::AMON_CW,
  parameter int unsigned DW   = amon_pkg::AMON_DW,
  localparam int unsigned SW  = (NCFG > 1) ? $clog2(NCFG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic             tick_i,
  input  logic [SW-1:0]    cfg_sel,
  input  logic [NCFG*CW-1:0] upper_thr,
  input  logic [NCFG*CW-1:0] lower_thr,
  input  logic [NCFG*CW-1:0] bucket_sz,
  input  logic [NCFG*DW-1:0] decay_exp,
  output logic             alarm_o
);
  logic [CW-1:0] up_arr [NCFG];
  logic [CW-1:0] lo_arr [NCFG];
  logic [CW-1:0] sz_arr [NCFG];
  logic [DW-1:0] dk_arr [NCFG];

  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    assign up_arr[k] = upper_thr[k*CW +: CW];
    assign lo_arr[k] = lower_thr[k*CW +: CW];
    assign sz_arr[k] = bucket_sz[k*CW +: CW];
    assign dk_arr[k] = decay_exp[k*DW +: DW];
  end

  logic [CW-1:0] up_sel, lo_sel, sz_sel;
  logic [DW-1:0] dk_sel;
  logic          act_smp;
  logic [CW-1:0] cnt_q, cnt_d;

  assign up_sel = up_arr[cfg_sel];
  assign lo_sel = lo_arr[cfg_sel];
  assign sz_sel = sz_arr[cfg_sel];
  assign dk_sel = dk_arr[cfg_sel];

  amon_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .tick(tick_i), .act(act_smp)
  );

  amon_bucket #(.CW(CW), .DW(DW)) u_bucket (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .act(act_smp),
    .size(sz_sel), .decay(dk_sel), .cnt_q(cnt_q), .cnt_d(cnt_d)
  );

  amon_alarm #(.CW(CW)) u_alarm (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .cnt_d(cnt_d),
    .upper(up_sel), .lower(lo_sel), .alarm_q(alarm_o)
  );
endmodule

// File: rtl/amon_checker.sv
module amon_checker #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          act,
  input logic [CW-1:0] count,
  input logic [CW-1:0] size,
  input logic [CW-1:0] upper,
  input logic [CW-1:0] lower,
  input logic          alarm
);
  assert_alarm_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alarm) |-> $past(tick));

  assert_fill_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !act && count < size) |=> (count == $past(count) + 1'b1));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !act && count >= size) |=> (count == $past(size)));

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && act && count == '0) |=> (count == '0));

  assert_clear_at_lower_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm) |-> (count <= $past(lower)));

  assert_raise_at_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> (count >= $past(upper)));
endmodule

bind amon_leaky_bucket amon_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_i), .act(act_smp), .count(cnt_q),
  .size(sz_sel), .upper(up_sel), .lower(lo_sel), .alarm(alarm_o)
);

// File: tb/amon_leaky_bucket_tb_top.sv
module amon_leaky_bucket_tb_top;
  localparam int NCFG = 4;
  localparam int CW   = 8;
  localparam int DW   = 3;
  localparam int IV   = 16;

  typedef struct { bit exp; string tag; } item_t;

  logic clk, rst_n, ref_clk, tick_i, alarm_o;
  logic [1:0] cfg_sel;
  logic [NCFG*CW-1:0] upper_thr, lower_thr, bucket_sz;
  logic [NCFG*DW-1:0] decay_exp;

  int checks = 0, failures = 0;
  bit done = 0;
  item_t q[$];

  int m_cnt, m_dcnt;
  bit m_alarm;

  amon_leaky_bucket dut_i (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .tick_i(tick_i),
    .cfg_sel(cfg_sel), .upper_thr(upper_thr), .lower_thr(lower_thr),
    .bucket_sz(bucket_sz), .decay_exp(decay_exp), .alarm_o(alarm_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic set_cfg(input int k, input int up, input int lo, input int sz, input int dk);
    upper_thr[k*CW +: CW] = CW'(up);
    lower_thr[k*CW +: CW] = CW'(lo);
    bucket_sz[k*CW +: CW] = CW'(sz);
    decay_exp[k*DW +: DW] = DW'(dk);
  endtask

  task automatic model_step(input bit act);
    int up, lo, sz, dk;
    up = int'(upper_thr[cfg_sel*CW +: CW]);
    lo = int'(lower_thr[cfg_sel*CW +: CW]);
    sz = int'(bucket_sz[cfg_sel*CW +: CW]);
    dk = int'(decay_exp[cfg_sel*DW +: DW]);
    if (!act) begin
      m_dcnt = 0;
      m_cnt  = (m_cnt >= sz) ? sz : m_cnt + 1;
    end else if (m_dcnt == (1 << dk) - 1) begin
      m_dcnt = 0;
      if (m_cnt > 0) m_cnt = m_cnt - 1;
    end else begin
      m_dcnt = m_dcnt + 1;
    end
    m_alarm = m_alarm ? (m_cnt > lo) : (m_cnt >= up);
  endtask

  // driver: one sampling interval, then push the expected alarm
  task automatic run_iv(input bit act, input string tag);
    item_t it;
    for (int i = 0; i < IV - 1; i++) begin
      @(negedge clk);
      ref_clk = act && (i >= 2) && (i < 6);
    end
    @(negedge clk);
    tick_i = 1'b1;
    model_step(act);
    @(negedge clk);
    tick_i = 1'b0;
    it.exp = m_alarm;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic run_n(input int n, input bit act, input string tag);
    for (int i = 0; i < n; i++) run_iv(act, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (alarm_o !== it.exp) begin
          failures++;
          $display("FAIL %s alarm actual=%0b expected=%0b", it.tag, alarm_o, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ref_clk = 0; tick_i = 0; cfg_sel = 0;
    upper_thr = '0; lower_thr = '0; bucket_sz = '0; decay_exp = '0;
    set_cfg(0, 6, 4, 8, 1);
    set_cfg(1, 2, 0, 3, 0);
    set_cfg(2, 3, 1, 5, 2);
    set_cfg(3, 1, 0, 1, 0);
    m_cnt = 0; m_dcnt = 0; m_alarm = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (alarm_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset alarm actual=%0b expected=0", alarm_o);
    end
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_n(2, 1'b1, "R1_idle");
    // R2: six empty intervals raise the alarm (R7 active pulses do not)
    run_n(6, 1'b0, "R2_fill");
    // R3: saturate well past size 8
    run_n(10, 1'b0, "R3_saturate");
    // R5: partial drain keeps alarm, R4/R3: exact clear after 8 active
    run_n(3, 1'b1, "R5_hold");
    run_n(5, 1'b1, "R4_drain");
    // R6: long active run then upper count again needed
    run_n(20, 1'b1, "R6_floor");
    run_n(6, 1'b0, "R6_refill");
    run_n(12, 1'b1, "R7_active");
    // R8: intermittent with decay 1 still raises
    run_n(20, 1'b1, "R8_empty");
    for (int i = 0; i < 7; i++) begin
      run_iv(1'b0, "R8_intermittent");
      run_iv(1'b1, "R8_intermittent");
    end
    run_n(20, 1'b1, "R8_empty");
    // R9: select set 1 (decay 0), alternating never raises
    @(negedge clk);
    cfg_sel = 2'd1;
    set_cfg(0, 1, 0, 1, 0);
    for (int i = 0; i < 6; i++) begin
      run_iv(1'b0, "R4_decay0");
      run_iv(1'b1, "R4_decay0");
    end
    run_n(2, 1'b0, "R9_sel1_raise");
    run_n(4, 1'b1, "R9_sel1_clear");
    @(negedge clk);
    cfg_sel = 2'd2;
    run_n(7, 1'b0, "R9_sel2_fill");
    run_n(20, 1'b1, "R9_sel2_drain");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule